// File: doc/BRIEF.md
# Cell-Averaging CFAR Detector

This block decides, cell by cell, whether a range-Doppler magnitude map contains a target. The map arrives one Doppler column at a time. Each column is a run of unsigned magnitudes ordered by range bin, starting at bin 0. The block holds a whole column. It then walks the range axis and, for every cell under test, averages the training cells on both sides of it. Guard cells next to the cell under test are skipped. The cell is declared a target only when its magnitude is above that average times a programmable scale, and also above a fixed floor.

The guard width, training width, Q4.4 scale, absolute floor and a 2-bit mode code all come from host registers. The block samples them together with the first magnitude of each column. It produces one result per cell, in range order. Each result carries a hit flag, the range index and the Doppler column index. The default build has 64 range bins by 32 Doppler columns, so range and Doppler together form an 11-bit cell address. While the block is scanning, `in_ready` is low and the source must hold its next sample.

Top module: `cacfar_detector`

## Requirements
- R1: After reset, `in_ready` is high and `res_valid` is low, and the first column scanned is reported as Doppler index 0.
- R2: While `in_ready` is high, each cycle with `in_valid` high stores one sample, in range order from bin 0. After the N_RANGE-th sample, `in_ready` stays low until the result for the last range bin of that column is presented.
- R3: Each column yields exactly N_RANGE results, with `res_range` counting up from 0. `res_doppler` is the same for the whole column. It rises by one for each new column and wraps to 0 after N_DOPPLER-1.
- R4: The noise estimate for cell r is floor(sum/count) over the cells at distance guard+1 through guard+train on each side of r. The cell itself and the cells within the guard distance are never included.
- R5: The scale is Q4.4: bits 7:4 are the integer part and bits 3:0 the fraction, so 0x30 means 3.0. The threshold is floor(noise × scale / 16).
- R6: `res_hit` is 1 exactly when the cell magnitude is strictly greater than the threshold of R5 and strictly greater than the absolute floor. A value equal to either limit is not a hit.
- R7: Near either end of the range axis, training positions outside 0..N_RANGE-1 are left out, and the divisor is the number of positions actually summed.
- R8: With a training width of 0 the noise estimate and threshold are 0, so a cell is a hit exactly when its magnitude exceeds the absolute floor.
- R9: Mode code 2'b00 selects cell averaging. Codes 2'b01, 2'b10 and 2'b11 give exactly the same results as 2'b00.
- R10: The configuration inputs are sampled in the cycle the first magnitude of a column is accepted. Changes during the rest of that column do not affect its results.
- R11: A training width above 16 behaves as 16. Any guard width from 0 to 7 is honoured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_guard | input | 3 | Guard cells on each side of the cell under test |
| cfg_train | input | 5 | Training cells on each side (values above 16 clamp to 16) |
| cfg_scale | input | 8 | Threshold scale, unsigned Q4.4 |
| cfg_mode | input | 2 | Detector mode code (00 = cell averaging) |
| cfg_abs_thr | input | 16 | Absolute magnitude floor |
| in_valid | input | 1 | A magnitude is offered on `in_mag` |
| in_mag | input | 16 | Unsigned magnitude of the next range bin |
| in_ready | output | 1 | High while the block is loading a column |
| res_valid | output | 1 | A result is presented this cycle |
| res_hit | output | 1 | Cell under test is a detection |
| res_range | output | 6 | Range index of the result |
| res_doppler | output | 5 | Doppler column index of the result |

## Verification
The embedded properties are checked on every cycle. They cover the handshake order: `in_ready` drops only after an accepted sample, stays low between results, and comes back together with the last bin's result. They also check that the sampled configuration holds still during a scan, that the training count never exceeds twice the sampled width, and that no hit appears at or below the absolute floor. Whether the averaged noise, the Q4.4 scaling, the edge divisors, the clamping and the mode fallback give the right decisions can only be shown by the bench. Its scenarios compare every result against a model that recomputes each window from the column it sent, including the exact-equality and zero-training cases and a run long enough to wrap the Doppler index.

// File: rtl/cacfar_pkg.sv
package cacfar_pkg;

  localparam int MAG_W      = 16;
  localparam int SCALE_W    = 8;
  localparam int SCALE_FRAC = 4;
  localparam int MODE_W     = 2;
  localparam int MAX_TRAIN  = 16;
  localparam int J_W        = $clog2(MAX_TRAIN + 1);
  localparam int CNT_W      = $clog2(2 * MAX_TRAIN + 1);
  localparam int SUM_W      = MAG_W + CNT_W;
  localparam int THR_W      = MAG_W + SCALE_W;

  typedef logic [MAG_W-1:0]   mag_t;
  typedef logic [SUM_W-1:0]   sum_t;
  typedef logic [CNT_W-1:0]   cnt_t;
  typedef logic [THR_W-1:0]   thr_t;
  typedef logic [SCALE_W-1:0] scale_t;
  typedef logic [MODE_W-1:0]  mode_t;

  typedef enum logic [1:0] {
    ST_LOAD = 2'd0,
    ST_ACC  = 2'd1,
    ST_CMP  = 2'd2
  } seq_state_e;

  localparam mode_t MODE_CELL_AVG = 2'b00;

  // True when c is a nonzero power of two.
  function automatic logic is_pow2(cnt_t c);
    return (c != '0) && ((c & (c - 1'b1)) == '0);
  endfunction

  // Bit position of the single set bit of a power of two.
  function automatic int log2_exact(cnt_t c);
    int r;
    r = 0;
    for (int i = 0; i < CNT_W; i++) begin
      if (c[i]) r = i;
    end
    return r;
  endfunction

  // Floor of s / c; zero when no training cell contributed.
  function automatic mag_t noise_avg(sum_t s, cnt_t c);
    sum_t             q;
    logic [CNT_W:0]   rem;
    q   = '0;
    rem = '0;
    if (c == '0) begin
      q = '0;
    end else if (is_pow2(c)) begin
      q = s >> log2_exact(c);
    end else begin
      for (int i = SUM_W - 1; i >= 0; i--) begin
        rem = {rem[CNT_W-1:0], s[i]};
        if (rem >= {1'b0, c}) begin
          rem  = rem - {1'b0, c};
          q[i] = 1'b1;
        end
      end
    end
    return mag_t'(q);
  endfunction

  // Noise level times an unsigned fixed-point scale, fraction dropped.
  function automatic thr_t scaled_threshold(mag_t avg, scale_t k);
    thr_t p;
    p = thr_t'(avg) * thr_t'(k);
    return p >> SCALE_FRAC;
  endfunction

  // Both limits must be exceeded strictly.
  function automatic logic is_detection(mag_t m, thr_t thr, mag_t floor_v);
    return (thr_t'(m) > thr) && (m > floor_v);
  endfunction

endpackage

// File: rtl/cacfar_colbuf.sv
module cacfar_colbuf
  import cacfar_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  mag_t          wr_data_i,
  input  logic [AW-1:0] cut_addr_i,
  input  logic [AW-1:0] lo_addr_i,
  input  logic [AW-1:0] hi_addr_i,
  output mag_t          cut_data_o,
  output mag_t          lo_data_o,
  output mag_t          hi_data_o
);

  mag_t cells_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) cells_q[wr_addr_i] <= wr_data_i;
  end

  assign cut_data_o = cells_q[cut_addr_i];
  assign lo_data_o  = cells_q[lo_addr_i];
  assign hi_data_o  = cells_q[hi_addr_i];

endmodule

// File: rtl/cacfar_seq.sv
module cacfar_seq
  import cacfar_pkg::*;
#(
  parameter int N_RANGE   = 64,
  parameter int N_DOPPLER = 32,
  parameter int GUARD_W   = 3,
  parameter int TRAIN_W   = 5,
  localparam int RIDX_W   = $clog2(N_RANGE),
  localparam int DIDX_W   = $clog2(N_DOPPLER)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [GUARD_W-1:0] cfg_guard_i,
  input  logic [TRAIN_W-1:0] cfg_train_i,
  input  scale_t             cfg_scale_i,
  input  mode_t              cfg_mode_i,
  input  mag_t               cfg_abs_i,
  output logic               wr_en_o,
  output logic [RIDX_W-1:0]  wr_addr_o,
  output logic [RIDX_W-1:0]  cut_o,
  output logic [RIDX_W-1:0]  lo_addr_o,
  output logic [RIDX_W-1:0]  hi_addr_o,
  output logic               lo_ok_o,
  output logic               hi_ok_o,
  output logic               add_en_o,
  output logic               fire_o,
  output logic [DIDX_W-1:0]  doppler_o,
  output logic [J_W-1:0]     lat_train_o,
  output scale_t             lat_scale_o,
  output mode_t              lat_mode_o,
  output mag_t               lat_abs_o
);

  localparam int EXT_W = RIDX_W + GUARD_W + J_W + 1;
  localparam logic [RIDX_W-1:0] LAST_R = RIDX_W'(N_RANGE - 1);
  localparam logic [DIDX_W-1:0] LAST_D = DIDX_W'(N_DOPPLER - 1);

  seq_state_e         state_q;
  logic [RIDX_W-1:0]  wr_idx_q;
  logic [RIDX_W-1:0]  cut_q;
  logic [J_W-1:0]     j_q;
  logic [DIDX_W-1:0]  dop_q;
  logic [GUARD_W-1:0] lat_guard_q;
  logic [J_W-1:0]     lat_train_q;
  scale_t             lat_scale_q;
  mode_t              lat_mode_q;
  mag_t               lat_abs_q;

  // Named events
  logic col_start_w;   // first magnitude of a column accepted
  logic col_loaded_w;  // last magnitude of a column accepted
  logic cell_done_w;   // decision issued for the current cell
  logic col_done_w;    // decision issued for the last bin
  logic window_end_w;  // last training offset of this cell
  logic [J_W-1:0] train_clamped_w;
  seq_state_e     cell_entry_w;

  logic [EXT_W-1:0] cut_ext_w, dist_w, hi_ext_w;

  assign in_ready_o   = (state_q == ST_LOAD);
  assign wr_en_o      = in_ready_o && in_valid_i;
  assign col_start_w  = wr_en_o && (wr_idx_q == '0);
  assign col_loaded_w = wr_en_o && (wr_idx_q == LAST_R);
  assign add_en_o     = (state_q == ST_ACC);
  assign fire_o       = (state_q == ST_CMP);
  assign cell_done_w  = fire_o;
  assign col_done_w   = fire_o && (cut_q == LAST_R);
  assign window_end_w = add_en_o && (j_q == lat_train_q);
  assign cell_entry_w = (lat_train_q == '0) ? ST_CMP : ST_ACC;

  assign train_clamped_w = (int'(cfg_train_i) > MAX_TRAIN) ? J_W'(MAX_TRAIN)
                                                           : J_W'(cfg_train_i);

  // Training offset geometry for the current cell
  assign cut_ext_w = EXT_W'(cut_q);
  assign dist_w    = EXT_W'(lat_guard_q) + EXT_W'(j_q);
  assign hi_ext_w  = cut_ext_w + dist_w;
  assign lo_ok_o   = (dist_w <= cut_ext_w);
  assign hi_ok_o   = (hi_ext_w < EXT_W'(N_RANGE));
  assign lo_addr_o = RIDX_W'(cut_ext_w - dist_w);
  assign hi_addr_o = RIDX_W'(hi_ext_w);

  assign wr_addr_o   = wr_idx_q;
  assign cut_o       = cut_q;
  assign doppler_o   = dop_q;
  assign lat_train_o = lat_train_q;
  assign lat_scale_o = lat_scale_q;
  assign lat_mode_o  = lat_mode_q;
  assign lat_abs_o   = lat_abs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_LOAD;
      wr_idx_q    <= '0;
      cut_q       <= '0;
      j_q         <= J_W'(1);
      dop_q       <= '0;
      lat_guard_q <= GUARD_W'(2);
      lat_train_q <= J_W'(8);
      lat_scale_q <= scale_t'(8'h30);
      lat_mode_q  <= MODE_CELL_AVG;
      lat_abs_q   <= mag_t'(10000);
    end else begin
      case (state_q)
        ST_LOAD: begin
          if (col_start_w) begin
            lat_guard_q <= cfg_guard_i;
            lat_train_q <= train_clamped_w;
            lat_scale_q <= cfg_scale_i;
            lat_mode_q  <= cfg_mode_i;
            lat_abs_q   <= cfg_abs_i;
          end
          if (col_loaded_w) begin
            wr_idx_q <= '0;
            cut_q    <= '0;
            j_q      <= J_W'(1);
            state_q  <= cell_entry_w;
          end else if (wr_en_o) begin
            wr_idx_q <= wr_idx_q + 1'b1;
          end
        end
        ST_ACC: begin
          if (window_end_w) state_q <= ST_CMP;
          else              j_q     <= j_q + 1'b1;
        end
        ST_CMP: begin
          j_q <= J_W'(1);
          if (col_done_w) begin
            cut_q   <= '0;
            dop_q   <= (dop_q == LAST_D) ? '0 : dop_q + 1'b1;
            state_q <= ST_LOAD;
          end else begin
            cut_q   <= cut_q + 1'b1;
            state_q <= cell_entry_w;
          end
        end
        default: state_q <= ST_LOAD;
      endcase
    end
  end

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready_o |-> $stable({lat_guard_q, lat_train_q, lat_scale_q, lat_mode_q, lat_abs_q}))
    else $error("sampled configuration moved during a scan");

endmodule

// File: rtl/cacfar_accum.sv
module cacfar_accum
  import cacfar_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic add_en_i,
  input  logic lo_ok_i,
  input  logic hi_ok_i,
  input  mag_t lo_val_i,
  input  mag_t hi_val_i,
  output sum_t sum_o,
  output cnt_t cnt_o
);

  sum_t sum_q;
  cnt_t cnt_q;
  sum_t step_sum_w;
  cnt_t step_cnt_w;

  assign step_sum_w = (lo_ok_i ? sum_t'(lo_val_i) : '0) + (hi_ok_i ? sum_t'(hi_val_i) : '0);
  assign step_cnt_w = cnt_t'(lo_ok_i) + cnt_t'(hi_ok_i);

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      sum_q <= '0;
      cnt_q <= '0;
    end else if (add_en_i) begin
      sum_q <= sum_q + step_sum_w;
      cnt_q <= cnt_q + step_cnt_w;
    end
  end

  assign sum_o = sum_q;
  assign cnt_o = cnt_q;

endmodule

// File: rtl/cacfar_decide.sv
module cacfar_decide
  import cacfar_pkg::*;
#(
  parameter int RIDX_W = 6,
  parameter int DIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  mag_t              cut_mag_i,
  input  sum_t              sum_i,
  input  cnt_t              cnt_i,
  input  scale_t            scale_i,
  input  mag_t              abs_thr_i,
  input  mode_t             mode_i,
  input  logic [RIDX_W-1:0] range_i,
  input  logic [DIDX_W-1:0] doppler_i,
  output logic              res_valid_o,
  output logic              res_hit_o,
  output logic [RIDX_W-1:0] res_range_o,
  output logic [DIDX_W-1:0] res_doppler_o
);

  mag_t avg_w;
  mag_t noise_w;
  thr_t thr_w;
  logic hit_now_w;

  assign avg_w = noise_avg(sum_i, cnt_i);

  // Only cell averaging exists; other codes fall back to it.
  always_comb begin
    case (mode_i)
      MODE_CELL_AVG: noise_w = avg_w;
      default:       noise_w = avg_w;
    endcase
  end

  assign thr_w     = scaled_threshold(noise_w, scale_i);
  assign hit_now_w = is_detection(cut_mag_i, thr_w, abs_thr_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid_o   <= 1'b0;
      res_hit_o     <= 1'b0;
      res_range_o   <= '0;
      res_doppler_o <= '0;
    end else begin
      res_valid_o <= fire_i;
      if (fire_i) begin
        res_hit_o     <= hit_now_w;
        res_range_o   <= range_i;
        res_doppler_o <= doppler_i;
      end
    end
  end

  // R6
  hit_above_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o && res_hit_o |-> $past(cut_mag_i) > $past(abs_thr_i))
    else $error("detection reported at or below the absolute floor");

endmodule

// File: rtl/cacfar_detector.sv
module cacfar_detector
  import cacfar_pkg::*;
#(
  parameter int N_RANGE   = 64,
  parameter int N_DOPPLER = 32,
  parameter int GUARD_W   = 3,
  parameter int TRAIN_W   = 5,
  localparam int RIDX_W   = $clog2(N_RANGE),
  localparam int DIDX_W   = $clog2(N_DOPPLER)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [GUARD_W-1:0] cfg_guard,
  input  logic [TRAIN_W-1:0] cfg_train,
  input  logic [7:0]         cfg_scale,
  input  logic [1:0]         cfg_mode,
  input  logic [15:0]        cfg_abs_thr,
  input  logic               in_valid,
  input  logic [15:0]        in_mag,
  output logic               in_ready,
  output logic               res_valid,
  output logic               res_hit,
  output logic [RIDX_W-1:0]  res_range,
  output logic [DIDX_W-1:0]  res_doppler
);

  logic              wr_en_w;
  logic [RIDX_W-1:0] wr_addr_w, cut_w, lo_addr_w, hi_addr_w;
  logic              lo_ok_w, hi_ok_w, add_en_w, fire_w;
  logic [DIDX_W-1:0] doppler_w;
  logic [J_W-1:0]    lat_train_w;
  scale_t            lat_scale_w;
  mode_t             lat_mode_w;
  mag_t              lat_abs_w;
  mag_t              cut_mag_w, lo_mag_w, hi_mag_w;
  sum_t              sum_w;
  cnt_t              cnt_w;

  cacfar_seq #(
    .N_RANGE  (N_RANGE),
    .N_DOPPLER(N_DOPPLER),
    .GUARD_W  (GUARD_W),
    .TRAIN_W  (TRAIN_W)
  ) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid_i (in_valid),
    .in_ready_o (in_ready),
    .cfg_guard_i(cfg_guard),
    .cfg_train_i(cfg_train),
    .cfg_scale_i(cfg_scale),
    .cfg_mode_i (cfg_mode),
    .cfg_abs_i  (cfg_abs_thr),
    .wr_en_o    (wr_en_w),
    .wr_addr_o  (wr_addr_w),
    .cut_o      (cut_w),
    .lo_addr_o  (lo_addr_w),
    .hi_addr_o  (hi_addr_w),
    .lo_ok_o    (lo_ok_w),
    .hi_ok_o    (hi_ok_w),
    .add_en_o   (add_en_w),
    .fire_o     (fire_w),
    .doppler_o  (doppler_w),
    .lat_train_o(lat_train_w),
    .lat_scale_o(lat_scale_w),
    .lat_mode_o (lat_mode_w),
    .lat_abs_o  (lat_abs_w)
  );

  cacfar_colbuf #(
    .DEPTH(N_RANGE),
    .AW   (RIDX_W)
  ) buf_i (
    .clk       (clk),
    .wr_en_i   (wr_en_w),
    .wr_addr_i (wr_addr_w),
    .wr_data_i (in_mag),
    .cut_addr_i(cut_w),
    .lo_addr_i (lo_addr_w),
    .hi_addr_i (hi_addr_w),
    .cut_data_o(cut_mag_w),
    .lo_data_o (lo_mag_w),
    .hi_data_o (hi_mag_w)
  );

  cacfar_accum acc_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (fire_w),
    .add_en_i(add_en_w),
    .lo_ok_i (lo_ok_w),
    .hi_ok_i (hi_ok_w),
    .lo_val_i(lo_mag_w),
    .hi_val_i(hi_mag_w),
    .sum_o   (sum_w),
    .cnt_o   (cnt_w)
  );

  cacfar_decide #(
    .RIDX_W(RIDX_W),
    .DIDX_W(DIDX_W)
  ) dec_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .fire_i       (fire_w),
    .cut_mag_i    (cut_mag_w),
    .sum_i        (sum_w),
    .cnt_i        (cnt_w),
    .scale_i      (lat_scale_w),
    .abs_thr_i    (lat_abs_w),
    .mode_i       (lat_mode_w),
    .range_i      (cut_w),
    .doppler_i    (doppler_w),
    .res_valid_o  (res_valid),
    .res_hit_o    (res_hit),
    .res_range_o  (res_range),
    .res_doppler_o(res_doppler)
  );

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(in_valid))
    else $error("in_ready fell without an accepted sample");

  // R2
  busy_between_results_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (res_range != RIDX_W'(N_RANGE - 1)) |-> !in_ready)
    else $error("ready raised before the column was finished");

  // R3
  ready_returns_with_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> res_valid && (res_range == RIDX_W'(N_RANGE - 1)))
    else $error("ready returned without the last-bin result");

  // R4
  train_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_w) <= 2 * int'(lat_train_w))
    else $error("training count exceeds both windows");

endmodule

// File: tb/cacfar_detector_tb_top.sv
module cacfar_detector_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NR = 64;
  localparam int ND = 32;

  logic        clk, rst_n;
  logic [2:0]  cfg_guard;
  logic [4:0]  cfg_train;
  logic [7:0]  cfg_scale;
  logic [1:0]  cfg_mode;
  logic [15:0] cfg_abs_thr;
  logic        in_valid;
  logic [15:0] in_mag;
  logic        in_ready, res_valid, res_hit;
  logic [5:0]  res_range;
  logic [4:0]  res_doppler;

  cacfar_detector dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_guard(cfg_guard), .cfg_train(cfg_train), .cfg_scale(cfg_scale),
    .cfg_mode(cfg_mode), .cfg_abs_thr(cfg_abs_thr),
    .in_valid(in_valid), .in_mag(in_mag), .in_ready(in_ready),
    .res_valid(res_valid), .res_hit(res_hit),
    .res_range(res_range), .res_doppler(res_doppler)
  );

  typedef struct {
    bit    hit;
    int    rng;
    int    dop;
    string tag;
  } exp_t;

  exp_t        expq[$];
  int          n_checks = 0;
  int          n_errors = 0;
  int          exp_dop = 0;
  int          col[NR];
  int unsigned seed = 32'h1234_5678;
  bit          done = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int unsigned lcg();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  // Behavioural decision for one cell
  function automatic bit model_hit(int r, int g, int t, int k, int floor_v);
    int s = 0, c = 0, avg, thr;
    if (t > 16) t = 16;
    for (int j = 1; j <= t; j++) begin
      if (r - (g + j) >= 0) begin s += col[r - (g + j)]; c++; end
      if (r + (g + j) < NR) begin s += col[r + (g + j)]; c++; end
    end
    avg = (c == 0) ? 0 : s / c;
    thr = (avg * k) / 16;
    return (col[r] > thr) && (col[r] > floor_v);
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic fill_noise(int base, int spread);
    for (int r = 0; r < NR; r++) col[r] = base + int'(lcg() % spread);
  endtask

  task automatic send_column(string tag, bit perturb);
    int g = cfg_guard, t = cfg_train, k = cfg_scale, f = cfg_abs_thr;
    logic [2:0] sg = cfg_guard; logic [4:0] st = cfg_train;
    logic [7:0] sk = cfg_scale; logic [1:0] sm = cfg_mode; logic [15:0] sf = cfg_abs_thr;
    for (int r = 0; r < NR; r++) begin
      exp_t e;
      e.hit = model_hit(r, g, t, k, f);
      e.rng = r;
      e.dop = exp_dop;
      e.tag = tag;
      expq.push_back(e);
    end
    exp_dop = (exp_dop + 1) % ND;
    for (int r = 0; r < NR; r++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      if (perturb && r == 1) begin
        cfg_guard = 3'd7; cfg_train = 5'd1; cfg_scale = 8'hFF;
        cfg_mode = 2'b11; cfg_abs_thr = 16'd0;
      end
      in_valid = 1'b1;
      in_mag = 16'(col[r]);
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R2 ready low after last sample", int'(in_ready), 0);
    if (perturb) begin
      cfg_guard = sg; cfg_train = st; cfg_scale = sk; cfg_mode = sm; cfg_abs_thr = sf;
    end
  endtask

  task automatic drain();
    int n = 0;
    while (expq.size() != 0 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(expq.size() == 0, "R3 all results of the column delivered", expq.size(), 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  // Reference comparison on every clock
  always @(negedge clk) begin
    if (rst_n && res_valid && !done) begin
      if (expq.size() == 0) begin
        check(1'b0, "R3 unexpected result", int'(res_range), -1);
      end else begin
        exp_t e;
        e = expq.pop_front();
        n_checks++;
        if (res_hit !== e.hit || int'(res_range) != e.rng || int'(res_doppler) != e.dop) begin
          n_errors++;
          $display("FAIL %s: actual hit=%0d range=%0d doppler=%0d expected hit=%0d range=%0d doppler=%0d",
                   e.tag, res_hit, res_range, res_doppler, e.hit, e.rng, e.dop);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_mag = '0;
    cfg_guard = 3'd2; cfg_train = 5'd8; cfg_scale = 8'h30;
    cfg_mode = 2'b00; cfg_abs_thr = 16'd10000;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    check(res_valid == 1'b0, "R1 res_valid after reset", int'(res_valid), 0);

    // Default window, targets at both edges and inside the guard gap
    fill_noise(500, 100);
    col[0] = 20000; col[10] = 20000; col[20] = 21000; col[22] = 20500;
    col[40] = 20000; col[63] = 20000; col[61] = 12000;
    send_column("R4 R6 R7 default window", 1'b0);

    // Absolute floor gating
    fill_noise(1000, 100); col[30] = 5000; col[2] = 9000;
    send_column("R6 floor blocks scaled hit", 1'b0);
    cfg_abs_thr = 16'd4000;
    send_column("R6 floor lowered", 1'b0);

    // Exact equality at both limits
    for (int r = 0; r < NR; r++) col[r] = 100;
    col[30] = 300; col[50] = 301; col[5] = 301;
    cfg_abs_thr = 16'd300;
    send_column("R6 equality is no hit", 1'b0);

    // Fractional scales
    fill_noise(800, 400); col[12] = 1500; col[33] = 1300; col[47] = 2000;
    cfg_abs_thr = 16'd0;
    cfg_scale = 8'h18;
    send_column("R5 scale 1.5", 1'b0);
    cfg_scale = 8'h01;
    send_column("R5 scale 1/16", 1'b0);
    cfg_scale = 8'hFF;
    send_column("R5 scale max", 1'b0);

    // Non power-of-two divisors and ragged edges
    fill_noise(0, 4000);
    cfg_scale = 8'h14; cfg_guard = 3'd1; cfg_train = 5'd3; cfg_abs_thr = 16'd100;
    send_column("R4 R7 divisor six and edges", 1'b0);

    // No training cells
    fill_noise(0, 4000);
    cfg_train = 5'd0; cfg_abs_thr = 16'd2000;
    send_column("R8 zero training", 1'b0);

    // Reserved mode codes
    fill_noise(500, 600); col[7] = 3000; col[44] = 2200; col[45] = 2600;
    cfg_guard = 3'd2; cfg_train = 5'd8; cfg_scale = 8'h30; cfg_abs_thr = 16'd1000;
    for (int m = 1; m < 4; m++) begin
      cfg_mode = 2'(m);
      send_column("R9 reserved mode falls back", 1'b0);
    end
    cfg_mode = 2'b00;

    // Configuration change during a column
    fill_noise(300, 300); col[25] = 5000; col[26] = 900;
    send_column("R10 config sampled at first sample", 1'b1);

    // Training clamp and widest guard
    fill_noise(0, 3000); col[32] = 9000;
    cfg_guard = 3'd7; cfg_train = 5'd20; cfg_scale = 8'h1C; cfg_abs_thr = 16'd50;
    send_column("R11 train 20 acts as 16", 1'b0);
    cfg_train = 5'd31; cfg_guard = 3'd0;
    send_column("R11 train 31 and guard 0", 1'b0);

    // Enough columns to wrap the Doppler index
    cfg_guard = 3'd1; cfg_train = 5'd1; cfg_scale = 8'h20; cfg_abs_thr = 16'd10;
    for (int c = 0; c < 20; c++) begin
      fill_noise(0, 2000);
      send_column("R3 doppler index wrap", 1'b0);
    end
    drain();

    repeat (5) begin
      @(negedge clk);
      check(res_valid == 1'b0, "R3 no result when idle", int'(res_valid), 0);
    end
    check(in_ready == 1'b1, "R2 ready when idle", int'(in_ready), 1);
    done = 1'b1;
    finish_run();
  end

endmodule